// File: doc/BRIEF.md
# Prioritized Interrupt Request and In-Service Tracker

This block keeps a record of 256 numbered interrupt vectors in two sets: the vectors that are waiting (pending) and the vectors that the processor has taken and not yet finished (in service). Vector v lives in word v>>5, bit v&31 of each set, so each set is eight 32-bit words. A request input marks a vector pending. An accept strobe moves the highest pending vector into service, but only if its priority class, bits 7:4 of the vector number, is above the class of the highest in-service vector. An end-of-interrupt strobe retires the highest in-service vector. The highest pending and highest in-service vector numbers are always on the outputs. Each has a flag that says whether its set is empty, because an empty set reports vector 0.

Four special classes do not use the pending set: system management, non-maskable, init and external. Each class has its own pending flag and 8-bit vector. They are served in fixed order, and each flag is cleared by its own acknowledge bit. A summary output shows whether any of the three unmaskable classes is pending. The external class is not part of that summary.

Top module: `vec_prio_tracker`

## Requirements
- R1: A cycle with `req_valid` high marks vector `req_vec` pending. The change shows on the outputs from the next cycle.
- R2: `top_pend` is the highest-numbered pending vector and `pend_any` is high when any vector is pending. With none pending, `top_pend` is 0 and `pend_any` is 0. Vectors 0x1F and 0x20 lie in adjacent words, and both are ordered by number.
- R3: `top_serv` and `serv_any` report the in-service set with the same rule as R2.
- R4: `accept` moves `top_pend` from the pending set to the in-service set in one cycle. This happens when the in-service set is empty, or when `top_pend[7:4]` is strictly greater than `top_serv[7:4]`.
- R5: `accept` has no effect when the pending set is empty, or when the class of `top_pend` is equal to or below the class of `top_serv`.
- R6: `eoi` clears the highest in-service vector. It has no effect when the in-service set is empty.
- R7: If a request for a vector arrives in the same cycle that this vector is accepted, the vector stays pending and also enters service.
- R8: Special class index: bit 0 is system management, bit 1 is non-maskable, bit 2 is init and bit 3 is external. `sp_set[i]` sets flag `i` and latches `sp_vec_in` as the vector of class `i`. Every class set in the same cycle gets the same vector.
- R9: `sp_ack[i]` clears flag `i`. If `sp_set[i]` is high in the same cycle, the set wins.
- R10: `sp_sel` is the lowest-indexed pending class, `sp_sel_vec` is its vector and `sp_any` is high. With no special flag set, `sp_any`, `sp_sel` and `sp_sel_vec` are all 0.
- R11: `unmask_pend` is the OR of flags 0, 1 and 2. The external flag alone leaves it low.
- R12: Reset (`rst_n` low) clears both sets and all special flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| accept | input | 1 | Move the highest pending vector into service |
| eoi | input | 1 | Retire the highest in-service vector |
| pend_any | output | 1 | Pending set is not empty |
| top_pend | output | 8 | Highest pending vector |
| serv_any | output | 1 | In-service set is not empty |
| top_serv | output | 8 | Highest in-service vector |
| sp_set | input | 4 | Special class set strobes |
| sp_ack | input | 4 | Special class acknowledge strobes |
| sp_vec_in | input | 8 | Vector latched with `sp_set` |
| sp_pend | output | 4 | Special class pending flags |
| sp_any | output | 1 | Any special class pending |
| sp_sel | output | 2 | Class to serve next |
| sp_sel_vec | output | 8 | Vector of the class to serve next |
| unmask_pend | output | 1 | An unmaskable special class is pending |

## Verification
A wrong bit in either set shows at the ports one cycle after the strobe that should have changed it. It shows as a wrong `top_pend` or `top_serv` only while that bit is the highest one in its set. A lower wrong bit stays hidden until the vectors above it have been accepted or retired. For this reason the stimulus drains each set down through lower vectors, through the word boundary and down to vector 0. It also hits equal classes and strictly higher classes, to expose a wrong comparison. Special flags are set and acknowledged one at a time, so that each change of the served class is visible on `sp_sel` in the next cycle.

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int NVEC = WORDS * WORD_W,
  localparam int VW   = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vec,
  input  logic          accept,
  input  logic          eoi,
  output logic          pend_any,
  output logic [VW-1:0] top_pend,
  output logic          serv_any,
  output logic [VW-1:0] top_serv,
  input  logic [3:0]    sp_set,
  input  logic [3:0]    sp_ack,
  input  logic [VW-1:0] sp_vec_in,
  output logic [3:0]    sp_pend,
  output logic          sp_any,
  output logic [1:0]    sp_sel,
  output logic [VW-1:0] sp_sel_vec,
  output logic          unmask_pend
);

  logic [NVEC-1:0] pend, serv, pend_nx, serv_nx;
  logic [3:0][VW-1:0] sp_vec;
  logic acc_ok;

  // word-by-word scan; a later (higher) hit overrides an earlier one
  function automatic logic [VW:0] find_top(input logic [NVEC-1:0] a);
    logic [VW:0] r;
    r = '0;
    for (int w = 0; w < WORDS; w++)
      for (int b = 0; b < WORD_W; b++)
        if (a[w*WORD_W + b]) r = {1'b1, VW'(w*WORD_W + b)};
    return r;
  endfunction

  assign {pend_any, top_pend} = find_top(pend);
  assign {serv_any, top_serv} = find_top(serv);

  assign acc_ok = accept && pend_any &&
                  (!serv_any || (top_pend[VW-1:4] > top_serv[VW-1:4]));

  always_comb begin
    pend_nx = pend;
    serv_nx = serv;
    if (eoi && serv_any) serv_nx[top_serv] = 1'b0;
    if (acc_ok) begin
      pend_nx[top_pend] = 1'b0;
      serv_nx[top_pend] = 1'b1;
    end
    if (req_valid) pend_nx[req_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      serv <= '0;
    end else begin
      pend <= pend_nx;
      serv <= serv_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_pend <= '0;
      sp_vec  <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (sp_set[i]) begin
          sp_pend[i] <= 1'b1;
          sp_vec[i]  <= sp_vec_in;
        end else if (sp_ack[i]) begin
          sp_pend[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    sp_sel = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (sp_pend[i]) sp_sel = 2'(i);
  end

  assign sp_any      = |sp_pend;
  assign sp_sel_vec  = sp_any ? sp_vec[sp_sel] : '0;
  assign unmask_pend = |sp_pend[2:0];

  a_r1_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pend[$past(req_vec)]);

  a_r2_top_is_highest: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> ((pend >> top_pend) == NVEC'(1)));

  a_r3_serv_top_is_highest: assert property (@(posedge clk) disable iff (!rst_n)
    serv_any |-> ((serv >> top_serv) == NVEC'(1)));

  a_r4_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_any && (!serv_any || top_pend[VW-1:4] > top_serv[VW-1:4]))
      |=> serv[$past(top_pend)]);

  a_r5_blocked_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !eoi && serv_any && top_pend[VW-1:4] <= top_serv[VW-1:4])
      |=> $stable(serv));

  a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && serv_any) |=> !serv[$past(top_serv)]);

  a_r8_set_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_set != 4'd0) |=> ((sp_pend & $past(sp_set)) == $past(sp_set)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((sp_ack & ~sp_set) != 4'd0) |=> ((sp_pend & $past(sp_ack & ~sp_set)) == 4'd0));

endmodule

// File: tb/test_vec_prio_tracker.sv
module test_vec_prio_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, accept = 1'b0, eoi = 1'b0;
  logic [7:0] req_vec = '0, sp_vec_in = '0;
  logic [3:0] sp_set = '0, sp_ack = '0;
  logic pend_any, serv_any, sp_any, unmask_pend;
  logic [7:0] top_pend, top_serv, sp_sel_vec;
  logic [3:0] sp_pend;
  logic [1:0] sp_sel;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_prio_tracker i_vec_prio_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .accept(accept), .eoi(eoi), .pend_any(pend_any), .top_pend(top_pend),
    .serv_any(serv_any), .top_serv(top_serv), .sp_set(sp_set), .sp_ack(sp_ack),
    .sp_vec_in(sp_vec_in), .sp_pend(sp_pend), .sp_any(sp_any), .sp_sel(sp_sel),
    .sp_sel_vec(sp_sel_vec), .unmask_pend(unmask_pend));

  // {req_valid, req_vec, accept, eoi, exp pend_any, exp top_pend, exp serv_any, exp top_serv}
  localparam int NROW = 27;
  localparam logic [28:0] TBL [NROW] = '{
    {1'b1, 8'h21, 1'b0, 1'b0, 1'b1, 8'h21, 1'b0, 8'h00},  // R1
    {1'b1, 8'h85, 1'b0, 1'b0, 1'b1, 8'h85, 1'b0, 8'h00},  // R2
    {1'b1, 8'h3F, 1'b0, 1'b0, 1'b1, 8'h85, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3F, 1'b1, 8'h85},  // R4 empty service
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3F, 1'b1, 8'h85},  // R5 lower class
    {1'b1, 8'h9A, 1'b0, 1'b0, 1'b1, 8'h9A, 1'b1, 8'h85},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3F, 1'b1, 8'h9A},  // R4 higher class
    {1'b1, 8'h95, 1'b0, 1'b0, 1'b1, 8'h95, 1'b1, 8'h9A},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h95, 1'b1, 8'h9A},  // R5 equal class
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h95, 1'b1, 8'h85},  // R6
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3F, 1'b1, 8'h95},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h3F, 1'b1, 8'h85},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h3F, 1'b0, 8'h00},  // R3 empty
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h3F, 1'b0, 8'h00},  // R6 eoi on empty
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h21, 1'b1, 8'h3F},
    {1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h21, 1'b1, 8'h3F},  // R5 blocked + req
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h21, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h21},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h21},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00},  // R2 empty, vector 0
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00},  // R5 accept, empty pend
    {1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, 8'hFF},  // R7
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00},
    {1'b1, 8'h20, 1'b1, 1'b0, 1'b1, 8'h20, 1'b1, 8'hFF},
    {1'b1, 8'h1F, 1'b0, 1'b0, 1'b1, 8'h20, 1'b1, 8'hFF}   // R2 word boundary
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_sp(input string tag, input logic [3:0] p, input logic any,
                        input logic [1:0] sel, input logic [7:0] v, input logic um);
    chk(tag, {17'd0, sp_pend, sp_any, sp_sel, sp_sel_vec, unmask_pend},
             {17'd0, p, any, sel, v, um});
  endtask

  task automatic sp_step(input logic [3:0] s, input logic [3:0] a, input logic [7:0] v);
    sp_set = s; sp_ack = a; sp_vec_in = v;
    @(negedge clk);
    sp_set = '0; sp_ack = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset arrays", {14'd0, pend_any, top_pend, serv_any, top_serv}, 32'd0);
    chk_sp("R12 reset special", 4'b0000, 1'b0, 2'd0, 8'h00, 1'b0);

    for (int r = 0; r < NROW; r++) begin
      req_valid = TBL[r][28];
      req_vec   = TBL[r][27:20];
      accept    = TBL[r][19];
      eoi       = TBL[r][18];
      @(negedge clk);
      checks++;
      if ({pend_any, top_pend, serv_any, top_serv} !== TBL[r][17:0]) begin
        errors++;
        $display("FAIL R2 R3 row %0d actual=%h expected=%h", r,
                 {pend_any, top_pend, serv_any, top_serv}, TBL[r][17:0]);
      end
    end
    req_valid = 1'b0; accept = 1'b0; eoi = 1'b0;

    sp_step(4'b1000, 4'b0000, 8'h30);
    chk_sp("R11 external only", 4'b1000, 1'b1, 2'd3, 8'h30, 1'b0);
    sp_step(4'b0010, 4'b0000, 8'h02);
    chk_sp("R8 nmi set", 4'b1010, 1'b1, 2'd1, 8'h02, 1'b1);
    sp_step(4'b0101, 4'b0000, 8'h11);
    chk_sp("R10 smi first", 4'b1111, 1'b1, 2'd0, 8'h11, 1'b1);
    sp_step(4'b0000, 4'b0001, 8'h00);
    chk_sp("R9 ack smi", 4'b1110, 1'b1, 2'd1, 8'h02, 1'b1);
    sp_step(4'b0010, 4'b0010, 8'h07);
    chk_sp("R9 set wins", 4'b1110, 1'b1, 2'd1, 8'h07, 1'b1);
    sp_step(4'b0000, 4'b0010, 8'h00);
    chk_sp("R10 init next", 4'b1100, 1'b1, 2'd2, 8'h11, 1'b1);
    sp_step(4'b0000, 4'b0100, 8'h00);
    chk_sp("R11 only external left", 4'b1000, 1'b1, 2'd3, 8'h30, 1'b0);
    sp_step(4'b0000, 4'b1000, 8'h00);
    chk_sp("R10 none pending", 4'b0000, 1'b0, 2'd0, 8'h00, 1'b0);

    sp_step(4'b0110, 4'b0000, 8'h55);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset clears arrays", {14'd0, pend_any, top_pend, serv_any, top_serv}, 32'd0);
    chk_sp("R12 reset clears special", 4'b0000, 1'b0, 2'd0, 8'h00, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule